// File: doc/BRIEF.md
# Boot-Sector Map Decoder and Modify Guard

This block takes a 23-bit word address in a 128 Mbit flash array organised as four banks. It returns the bank, the sector number and a flag that marks the small sectors. The array is non-uniform. It is made of 32 Kword sectors, except at the lowest and highest 32 Kword of the space. Each of those two ends is split into eight 4 Kword sectors. Decoding is purely combinational, so a controller can look up any address in the same cycle it presents it.

The same lookup also judges whether a program or erase aimed at that address may go ahead. Four independent locks feed that judgement:

- a write-protect pin that guards the outermost boot sectors;
- an acceleration pin that freezes the whole array when held low;
- a per-sector persistent lock vector;
- a password lock.

The password lock is released only after a presented 64-bit value matches the stored one exactly. The match state is held in a register. A plain read query is never reported as protected.

Top module: `sect_guard`

## Requirements
- R1: `bank_o` is 0 for word addresses 0x000000–0x0FFFFF, 1 for 0x100000–0x3FFFFF, 2 for 0x400000–0x6FFFFF and 3 for 0x700000–0x7FFFFF.
- R2: `sector_o` is computed from the address as follows:
  - below 0x008000 it is addr/4096 (0–7);
  - at or above 0x7F8000 it is 262 + (addr−0x7F8000)/4096 (262–269);
  - otherwise it is 8 + (addr−0x008000)/32768 (8–261).
- R3: `boot_o` is 1 exactly when the address lies below 0x008000 or at or above 0x7F8000.
- R4: While `wp_n_i` is 0, a modifying operation on sectors 0–3 or 266–269 is protected. Sectors 4–265 are not affected by that pin.
- R5: While `acc_i` is 0, every modifying operation is protected, whatever the address.
- R6: Bit k of `lock_vec_i` set to 1 protects modifying operations on sector k and on no other sector.
- R7: Password lock behaves as follows:
  - While `pw_mode_i` is 1 and no match is held, modifying operations are protected.
  - The match flag is cleared by reset.
  - It is set at the clock edge where `pw_try_valid_i` is 1 and `pw_try_i` equals `pw_stored_i` in all 64 bits.
  - It is cleared at an edge where `pw_try_valid_i` is 1 with any mismatch.
  - The effect on `protected_o` is seen in the cycle after that edge.
- R8: `op_i` encodes the operation:
  - 0 is a read query; `protected_o` is always 0 for it.
  - 1 is program, 2 is erase and 3 is treated as a modify. All three are judged by the locks.
- R9: `bank_o`, `sector_o`, `boot_o` and `protected_o` follow `addr_i`, `op_i` and the pins within the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the password match register |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 23 | Word address to decode |
| op_i | input | 2 | Operation: 0 read query, 1 program, 2 erase, 3 modify |
| wp_n_i | input | 1 | Write-protect pin, low guards the outer boot sectors |
| acc_i | input | 1 | Acceleration pin level, low locks every sector |
| lock_vec_i | input | 270 | Persistent lock bit per sector |
| pw_mode_i | input | 1 | Password protection mode active |
| pw_stored_i | input | 64 | Stored password |
| pw_try_i | input | 64 | Presented password |
| pw_try_valid_i | input | 1 | Strobe: compare `pw_try_i` at this edge |
| bank_o | output | 2 | Bank index 0–3 |
| sector_o | output | 9 | Sector number 0–269 |
| boot_o | output | 1 | Address lies in a 4 Kword sector |
| protected_o | output | 1 | Modify request is denied |

## Verification
Two functions can meet in one cycle: the registered password match changing state and the combinational guard judging an address. The bench presents a password attempt while a program request stays on the address lines. It then judges `protected_o` just before and just after the compare edge. It checks that the verdict moves exactly one cycle after the strobe. The bench also stacks the write-protect pin, the acceleration pin and a sector lock on one boot-sector address. It then confirms that a read query to that same address still reports unprotected.

// File: rtl/sect_guard_pkg.sv
package sect_guard_pkg;

    localparam int ADDR_W     = 23;
    localparam int BIG_W      = 15;
    localparam int BOOT_W     = 12;
    localparam int SUB_W      = BIG_W - BOOT_W;
    localparam int SLOT_W     = ADDR_W - BIG_W;
    localparam int SLOTS      = 1 << SLOT_W;
    localparam int BOOT_END   = 1 << SUB_W;
    localparam int SECT_CNT   = (SLOTS - 2) + 2 * BOOT_END;
    localparam int SECT_W     = $clog2(SECT_CNT);
    localparam int TOP_BASE   = SECT_CNT - BOOT_END;
    localparam int WP_PER_END = 4;
    localparam int BANK_B_SLOT = 32;
    localparam int BANK_C_SLOT = 128;
    localparam int BANK_D_SLOT = 224;
    localparam int PW_W       = 64;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_ERASE   = 2'd2,
        OP_MODIFY  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        BANK_A = 2'd0,
        BANK_B = 2'd1,
        BANK_C = 2'd2,
        BANK_D = 2'd3
    } bank_e;

    typedef struct packed {
        bank_e             bank;
        logic [SECT_W-1:0] sector;
        logic              boot;
        logic              wp_zone;
    } loc_t;

    typedef struct packed {
        logic by_pin;
        logic by_acc;
        logic by_vec;
        logic by_pw;
    } deny_t;

    function automatic logic is_modify(input op_e op);
        return op != OP_READ;
    endfunction

    function automatic bank_e slot_bank(input logic [SLOT_W-1:0] slot);
        if (slot < SLOT_W'(BANK_B_SLOT))      return BANK_A;
        else if (slot < SLOT_W'(BANK_C_SLOT)) return BANK_B;
        else if (slot < SLOT_W'(BANK_D_SLOT)) return BANK_C;
        else                                  return BANK_D;
    endfunction

endpackage

// File: rtl/sect_map.sv
module sect_map
    import sect_guard_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output loc_t              loc_o
);
    logic [SLOT_W-1:0] slot;
    logic [SUB_W-1:0]  sub;
    logic              at_bottom;
    logic              at_top;

    assign slot      = addr_i[ADDR_W-1:BIG_W];
    assign sub       = addr_i[BIG_W-1:BOOT_W];
    assign at_bottom = (slot == '0);
    assign at_top    = (slot == '1);

    always_comb begin
        loc_o.bank = slot_bank(slot);
        loc_o.boot = at_bottom | at_top;
        if (at_bottom)
            loc_o.sector = SECT_W'(sub);
        else if (at_top)
            loc_o.sector = SECT_W'(TOP_BASE) + SECT_W'(sub);
        else
            loc_o.sector = SECT_W'(slot) + SECT_W'(BOOT_END - 1);
        loc_o.wp_zone = (at_bottom & (sub < SUB_W'(WP_PER_END)))
                      | (at_top & (sub >= SUB_W'(BOOT_END - WP_PER_END)));
    end
endmodule

// File: rtl/sect_pw_gate.sv
module sect_pw_gate
    import sect_guard_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_i,
    input  logic [PW_W-1:0] stored_i,
    input  logic [PW_W-1:0] try_i,
    input  logic            try_valid_i,
    output logic            lock_o
);
    localparam int LANES = PW_W / LANE_W;

    logic [LANES-1:0] lane_eq;
    logic             all_eq;
    logic             match_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (stored_i[g*LANE_W +: LANE_W] == try_i[g*LANE_W +: LANE_W]);
    end

    assign all_eq = &lane_eq;

    always_ff @(posedge clk) begin
        if (rst)
            match_q <= 1'b0;
        else if (try_valid_i)
            match_q <= all_eq;
    end

    assign lock_o = mode_i & ~match_q;

    // R7: a match only appears after a strobed, fully equal attempt
    a_r7_rise_needs_equal: assert property (@(posedge clk) disable iff (rst)
        $rose(match_q) |-> ($past(try_valid_i) && ($past(try_i) == $past(stored_i))));

    // R7: a held match is only dropped by a strobed mismatching attempt
    a_r7_fall_needs_try: assert property (@(posedge clk) disable iff (rst)
        $fell(match_q) |-> ($past(try_valid_i) && ($past(try_i) != $past(stored_i))));

    // R7: without a strobe the match state holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !try_valid_i |=> $stable(match_q));
endmodule

// File: rtl/sect_protect_eval.sv
module sect_protect_eval
    import sect_guard_pkg::*;
(
    input  op_e               op_i,
    input  loc_t              loc_i,
    input  logic              wp_n_i,
    input  logic              acc_i,
    input  logic [SECT_CNT-1:0] lock_vec_i,
    input  logic              pw_lock_i,
    output logic              protected_o
);
    deny_t deny;

    always_comb begin
        deny.by_pin = ~wp_n_i & loc_i.wp_zone;
        deny.by_acc = ~acc_i;
        deny.by_vec = lock_vec_i[loc_i.sector];
        deny.by_pw  = pw_lock_i;
        protected_o = is_modify(op_i) & (|deny);
    end
endmodule

// File: rtl/sect_guard.sv
module sect_guard
    import sect_guard_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [1:0]          op_i,
    input  logic                wp_n_i,
    input  logic                acc_i,
    input  logic [SECT_CNT-1:0] lock_vec_i,
    input  logic                pw_mode_i,
    input  logic [PW_W-1:0]     pw_stored_i,
    input  logic [PW_W-1:0]     pw_try_i,
    input  logic                pw_try_valid_i,
    output logic [1:0]          bank_o,
    output logic [SECT_W-1:0]   sector_o,
    output logic                boot_o,
    output logic                protected_o
);
    loc_t loc;
    logic pw_lock;
    op_e  op;

    assign op = op_e'(op_i);

    sect_map u_map (
        .addr_i (addr_i),
        .loc_o  (loc)
    );

    sect_pw_gate #(.LANE_W(16)) u_pw (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (pw_mode_i),
        .stored_i    (pw_stored_i),
        .try_i       (pw_try_i),
        .try_valid_i (pw_try_valid_i),
        .lock_o      (pw_lock)
    );

    sect_protect_eval u_eval (
        .op_i        (op),
        .loc_i       (loc),
        .wp_n_i      (wp_n_i),
        .acc_i       (acc_i),
        .lock_vec_i  (lock_vec_i),
        .pw_lock_i   (pw_lock),
        .protected_o (protected_o)
    );

    assign bank_o   = loc.bank;
    assign sector_o = loc.sector;
    assign boot_o   = loc.boot;

    // R2: sector number stays inside the map
    a_r2_sector_range: assert property (@(posedge clk) disable iff (rst)
        sector_o < SECT_W'(SECT_CNT));

    // R3: small-sector flag agrees with the sector number
    a_r3_boot_ends: assert property (@(posedge clk) disable iff (rst)
        boot_o == ((sector_o < SECT_W'(BOOT_END)) || (sector_o >= SECT_W'(TOP_BASE))));

    // R1: outer banks hold only their own sectors
    a_r1_bank_a_span: assert property (@(posedge clk) disable iff (rst)
        (bank_o == 2'd0) |-> (sector_o < SECT_W'(BOOT_END + BANK_B_SLOT - 1)));
    a_r1_bank_d_span: assert property (@(posedge clk) disable iff (rst)
        (bank_o == 2'd3) |-> (sector_o >= SECT_W'(BANK_D_SLOT + BOOT_END - 1)));

    // R8: a read query is never denied
    a_r8_read_open: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'd0) |-> !protected_o);

    // R5: acceleration pin low denies every modify
    a_r5_acc_lock: assert property (@(posedge clk) disable iff (rst)
        (!acc_i && op_i != 2'd0) |-> protected_o);

    // R4: outer four boot sectors at each end are guarded by the pin
    a_r4_pin_guard: assert property (@(posedge clk) disable iff (rst)
        (!wp_n_i && op_i != 2'd0 &&
         (sector_o < SECT_W'(WP_PER_END) || sector_o >= SECT_W'(SECT_CNT - WP_PER_END)))
        |-> protected_o);

    // R6: a set lock bit denies a modify on its sector
    a_r6_vec_lock: assert property (@(posedge clk) disable iff (rst)
        (op_i != 2'd0 && lock_vec_i[sector_o]) |-> protected_o);
endmodule

// File: tb/sect_guard_bench.sv
module sect_guard_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [22:0]  addr_i = '0;
    logic [1:0]   op_i = 2'd0;
    logic         wp_n_i = 1'b1;
    logic         acc_i = 1'b1;
    logic [269:0] lock_vec_i = '0;
    logic         pw_mode_i = 1'b0;
    logic [63:0]  pw_stored_i = 64'hC3A5_1F2E_0B9D_7654;
    logic [63:0]  pw_try_i = '0;
    logic         pw_try_valid_i = 1'b0;
    logic [1:0]   bank_o;
    logic [8:0]   sector_o;
    logic         boot_o;
    logic         protected_o;

    int runs = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sect_guard u_sect_guard (
        .clk(clk), .rst(rst), .addr_i(addr_i), .op_i(op_i),
        .wp_n_i(wp_n_i), .acc_i(acc_i), .lock_vec_i(lock_vec_i),
        .pw_mode_i(pw_mode_i), .pw_stored_i(pw_stored_i), .pw_try_i(pw_try_i),
        .pw_try_valid_i(pw_try_valid_i), .bank_o(bank_o), .sector_o(sector_o),
        .boot_o(boot_o), .protected_o(protected_o)
    );

    function automatic int exp_sector(input int a);
        if (a < 32'h8000)       return a / 4096;
        else if (a >= 32'h7F8000) return 262 + (a - 32'h7F8000) / 4096;
        else                    return 8 + (a - 32'h8000) / 32768;
    endfunction

    function automatic int exp_bank(input int a);
        if (a < 32'h100000)      return 0;
        else if (a < 32'h400000) return 1;
        else if (a < 32'h700000) return 2;
        else                     return 3;
    endfunction

    function automatic int exp_boot(input int a);
        return (a < 32'h8000 || a >= 32'h7F8000) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive after a falling edge, settle, leave the sample before the next rising edge
    task automatic put(input int a, input int op);
        @(negedge clk);
        addr_i = 23'(a);
        op_i   = 2'(op);
        #3;
    endtask

    task automatic t_reset;
        pw_mode_i = 1'b1;
        op_i = 2'd1;
        addr_i = 23'h200000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #3;
        chk("R7", "reset clears match, locked", int'(protected_o), 1);
        @(negedge clk);
        #3;
        chk("R7", "still locked after reset", int'(protected_o), 1);
        pw_mode_i = 1'b0;
        #1;
        chk("R7", "mode off unlocks", int'(protected_o), 0);
    endtask

    task automatic t_decode;
        int pts[15] = '{32'h000000, 32'h000FFF, 32'h001000, 32'h007FFF, 32'h008000,
                        32'h0FFFFF, 32'h100000, 32'h3FFFFF, 32'h400000, 32'h6FFFFF,
                        32'h700000, 32'h7F7FFF, 32'h7F8000, 32'h7FC000, 32'h7FFFFF};
        for (int i = 0; i < 15; i++) begin
            put(pts[i], 0);
            chk("R1", $sformatf("bank @%h", pts[i]), int'(bank_o), exp_bank(pts[i]));
            chk("R2", $sformatf("sector @%h", pts[i]), int'(sector_o), exp_sector(pts[i]));
            chk("R3", $sformatf("boot @%h", pts[i]), int'(boot_o), exp_boot(pts[i]));
        end
    endtask

    task automatic t_same_cycle;
        // R9: outputs change with address inside one low clock phase
        @(negedge clk);
        addr_i = 23'h005000;
        #2;
        chk("R9", "sector same cycle a", int'(sector_o), 5);
        addr_i = 23'h7FD000;
        #2;
        chk("R9", "sector same cycle b", int'(sector_o), 267);
    endtask

    task automatic t_pin;
        wp_n_i = 1'b0;
        put(32'h003000, 1); chk("R4", "sector 3 guarded", int'(protected_o), 1);
        put(32'h004000, 1); chk("R4", "sector 4 open", int'(protected_o), 0);
        put(32'h7F9000, 2); chk("R4", "sector 263 open", int'(protected_o), 0);
        put(32'h7FA000, 2); chk("R4", "sector 264 open", int'(protected_o), 0);
        put(32'h7FB000, 2); chk("R4", "sector 265 open", int'(protected_o), 0);
        put(32'h7FC000, 2); chk("R4", "sector 266 guarded", int'(protected_o), 1);
        put(32'h7FFFFF, 3); chk("R4", "sector 269 guarded", int'(protected_o), 1);
        put(32'h000000, 1); chk("R4", "sector 0 guarded", int'(protected_o), 1);
        put(32'h200000, 1); chk("R4", "big sector open", int'(protected_o), 0);
        wp_n_i = 1'b1;
        put(32'h003000, 1); chk("R4", "pin released", int'(protected_o), 0);
    endtask

    task automatic t_acc;
        acc_i = 1'b0;
        put(32'h400000, 1); chk("R5", "acc low program", int'(protected_o), 1);
        put(32'h7FFFFF, 2); chk("R5", "acc low erase", int'(protected_o), 1);
        put(32'h008000, 3); chk("R5", "acc low modify", int'(protected_o), 1);
        put(32'h400000, 0); chk("R8", "acc low read", int'(protected_o), 0);
        acc_i = 1'b1;
        put(32'h400000, 1); chk("R5", "acc high", int'(protected_o), 0);
    endtask

    task automatic t_vec;
        lock_vec_i = '0;
        lock_vec_i[100] = 1'b1;
        lock_vec_i[7] = 1'b1;
        put(8'd0 + (100 - 8) * 32768 + 32'h8000, 2);
        chk("R6", "sector 100 locked", int'(protected_o), 1);
        put((101 - 8) * 32768 + 32'h8000, 2);
        chk("R6", "sector 101 open", int'(protected_o), 0);
        put(32'h007000, 1); chk("R6", "sector 7 locked", int'(protected_o), 1);
        put(32'h006FFF, 1); chk("R6", "sector 6 open", int'(protected_o), 0);
        lock_vec_i = '0;
    endtask

    task automatic try_pw(input logic [63:0] v);
        @(negedge clk);
        pw_try_i = v;
        pw_try_valid_i = 1'b1;
        #3;
        chk("R7", "no change before edge", int'(protected_o), int'(pw_mode_i) == 1 ? -1 : 0);
    endtask

    task automatic t_password;
        pw_mode_i = 1'b1;
        put(32'h250000, 1);
        chk("R7", "mode on, no match", int'(protected_o), 1);
        // attempt differing only in the top bit
        @(negedge clk);
        pw_try_i = pw_stored_i ^ 64'h8000_0000_0000_0000;
        pw_try_valid_i = 1'b1;
        @(negedge clk);
        pw_try_valid_i = 1'b0;
        #3;
        chk("R7", "top bit mismatch keeps lock", int'(protected_o), 1);
        // exact attempt: lock stays until the compare edge, then opens
        @(negedge clk);
        pw_try_i = pw_stored_i;
        pw_try_valid_i = 1'b1;
        #3;
        chk("R7", "before compare edge", int'(protected_o), 1);
        @(negedge clk);
        pw_try_valid_i = 1'b0;
        #3;
        chk("R7", "after compare edge", int'(protected_o), 1 - 1);
        @(negedge clk);
        #3;
        chk("R7", "match held", int'(protected_o), 0);
        // attempt differing only in bit 0 drops the match
        @(negedge clk);
        pw_try_i = pw_stored_i ^ 64'h1;
        pw_try_valid_i = 1'b1;
        @(negedge clk);
        pw_try_valid_i = 1'b0;
        #3;
        chk("R7", "low bit mismatch relocks", int'(protected_o), 1);
        pw_mode_i = 1'b0;
        #1;
        chk("R7", "mode off", int'(protected_o), 0);
    endtask

    task automatic t_read_query;
        wp_n_i = 1'b0;
        acc_i = 1'b0;
        lock_vec_i = '1;
        pw_mode_i = 1'b1;
        put(32'h000000, 0); chk("R8", "read all locks bottom", int'(protected_o), 0);
        put(32'h7FFFFF, 0); chk("R8", "read all locks top", int'(protected_o), 0);
        put(32'h000000, 2); chk("R8", "erase all locks", int'(protected_o), 1);
        wp_n_i = 1'b1;
        acc_i = 1'b1;
        lock_vec_i = '0;
        pw_mode_i = 1'b0;
        put(32'h000000, 1); chk("R8", "program no locks", int'(protected_o), 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_decode();
        t_same_cycle();
        t_pin();
        t_acc();
        t_vec();
        t_password();
        t_read_query();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule